// File: doc/BRIEF.md
# Tape Read Byte-Pair Assembler with DMA Back-Pressure

This block takes bytes from a tape drive during a read operation and packs them into 16-bit words for host memory. The drive announces each byte with an active-low acknowledge that is not related to the local data clock. The block passes that acknowledge through a synchronizer chain. Only after that does it capture the data byte, so the drive's slow data settling never reaches a register. Bytes take turns between a low half and a high half of a holding word. A select bit decides which half is loaded next.

Each captured byte is answered with an active-low transfer strobe. The strobe stays low until the synchronized acknowledge goes away. Once the high half is filled, a DMA request is raised and held until a done pulse comes back. While the request is pending, the block does not answer a further acknowledge. Instead it remembers it and answers it in the cycle after the done pulse. That answered byte goes into the low half. The block works only while its read-operation enable is high. Dropping the enable returns the select, the remembered acknowledge, the strobe and the request to idle.

Top module: `tape_rd_pair_asm`

## Requirements
- R1: After reset `xfer_n` is 1, `dma_req` is 0 and `word_out` is 0.
- R2: `ack_n` passes through two synchronizer stages. When `ack_n` falls before clock edge k and a byte is accepted, `xfer_n` goes low at edge k+2 and is still high after edge k+1.
- R3: The first byte of a pair is stored in `word_out[7:0]`. The second byte is stored in `word_out[15:8]`. The other half keeps its value.
- R4: Each accepted byte drives `xfer_n` low. `xfer_n` returns high at the third clock edge after `ack_n` rises.
- R5: `dma_req` rises at the same edge that stores the high byte. It stays high until a `dma_done` pulse.
- R6: A `dma_done` pulse while `dma_req` is high clears `dma_req` at that edge. The next accepted byte then goes into `word_out[7:0]`.
- R7: An acknowledge that arrives while `dma_req` is high gets no `xfer_n` and leaves `word_out` unchanged. It is remembered and accepted one edge after the `dma_done` edge.
- R8: While `rd_op` is 0, acknowledges are ignored: `xfer_n` stays 1 and `word_out` does not change. Dropping `rd_op` clears `dma_req` at the next edge, and the next byte after re-enabling goes into the low half.
- R9: An acknowledge held low for many cycles is counted as one byte only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local data clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_op | input | 1 | Tape read operation enable |
| ack_n | input | 1 | Drive byte acknowledge, active low, asynchronous |
| tape_data | input | 8 | Byte from the drive |
| xfer_n | output | 1 | Byte taken strobe back to the drive, active low |
| dma_req | output | 1 | Word ready for a DMA write |
| dma_done | input | 1 | One-cycle pulse: the DMA write has finished |
| word_out | output | 16 | Assembled word, high byte in [15:8] |

## Verification
The checker module verifies these rules on every cycle:
- A fall of the strobe always follows an accepted byte.
- The strobe is released once the synchronized acknowledge is gone.
- No byte is accepted while a request is pending.
- The request rises only when the high half is written, and holds until the done pulse.
- A done pulse sends the select back to the low half.
- A low enable idles the outputs.

Only the bench scenarios can show the following:
- Exact byte placement in the word.
- The three-edge latency through the synchronizer.
- That an early third byte is answered exactly one edge after the done pulse.
- That a long acknowledge yields one byte.

// File: rtl/tape_rd_pkg.sv
package tape_rd_pkg;

  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_sel_t;

  function automatic half_sel_t flip_half(input half_sel_t cur);
    return (cur == HALF_LO) ? HALF_HI : HALF_LO;
  endfunction

  function automatic logic word_complete(input half_sel_t cur, input logic take);
    return take && (cur == HALF_HI);
  endfunction

endpackage

// File: rtl/tape_ack_sync.sv
module tape_ack_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_n,
  output logic ack_lvl,
  output logic ack_rise
);
  logic [STAGES-1:0] chain;
  logic              lvl_prev;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= ~ack_n;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_prev <= 1'b0;
    else        lvl_prev <= chain[STAGES-1];
  end

  assign ack_lvl  = chain[STAGES-1];
  assign ack_rise = chain[STAGES-1] & ~lvl_prev;
endmodule

// File: rtl/tape_byte_steer.sv
module tape_byte_steer
  import tape_rd_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int LANES = 2,
  localparam int WORD_W = BYTE_W * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  half_sel_t         sel,
  input  logic [BYTE_W-1:0] din,
  output logic [WORD_W-1:0] word
);
  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [BYTE_W-1:0] hold_q;
      logic              hit;
      assign hit = load && (int'(sel) == l);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   hold_q <= '0;
        else if (hit) hold_q <= din;
      end
      assign word[l*BYTE_W +: BYTE_W] = hold_q;
    end
  endgenerate
endmodule

// File: rtl/tape_hs_ctrl.sv
module tape_hs_ctrl
  import tape_rd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rd_op,
  input  logic      ack_lvl,
  input  logic      ack_rise,
  input  logic      dma_done,
  output logic      accept,
  output half_sel_t sel,
  output logic      held,
  output logic      xfer_act,
  output logic      dma_req
);
  // A byte is taken on a fresh acknowledge or a remembered one, never under a pending request
  assign accept = rd_op && !dma_req && ack_lvl && (ack_rise || held);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel      <= HALF_LO;
      held     <= 1'b0;
      xfer_act <= 1'b0;
      dma_req  <= 1'b0;
    end else if (!rd_op) begin
      sel      <= HALF_LO;
      held     <= 1'b0;
      xfer_act <= 1'b0;
      dma_req  <= 1'b0;
    end else begin
      if (accept)                   held <= 1'b0;
      else if (ack_rise && dma_req) held <= 1'b1;
      else if (!ack_lvl)            held <= 1'b0;

      if (!ack_lvl)    xfer_act <= 1'b0;
      else if (accept) xfer_act <= 1'b1;

      if (accept)                   sel <= flip_half(sel);
      else if (dma_req && dma_done) sel <= HALF_LO;

      if (word_complete(sel, accept)) dma_req <= 1'b1;
      else if (dma_done)              dma_req <= 1'b0;
    end
  end
endmodule

// File: rtl/tape_rd_pair_asm.sv
module tape_rd_pair_asm
  import tape_rd_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int SYNC_STAGES = 2,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_op,
  input  logic              ack_n,
  input  logic [BYTE_W-1:0] tape_data,
  output logic              xfer_n,
  output logic              dma_req,
  input  logic              dma_done,
  output logic [WORD_W-1:0] word_out
);
  logic      ack_lvl;
  logic      ack_rise;
  logic      accept;
  logic      held;
  logic      xfer_act;
  half_sel_t sel;

  tape_ack_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ack_n    (ack_n),
    .ack_lvl  (ack_lvl),
    .ack_rise (ack_rise)
  );

  tape_hs_ctrl ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_op    (rd_op),
    .ack_lvl  (ack_lvl),
    .ack_rise (ack_rise),
    .dma_done (dma_done),
    .accept   (accept),
    .sel      (sel),
    .held     (held),
    .xfer_act (xfer_act),
    .dma_req  (dma_req)
  );

  tape_byte_steer #(.BYTE_W(BYTE_W)) steer_i (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .sel   (sel),
    .din   (tape_data),
    .word  (word_out)
  );

  assign xfer_n = ~xfer_act;
endmodule

// File: rtl/tape_rd_pair_asm_chk.sv
module tape_rd_pair_asm_chk (
  input logic clk,
  input logic rst_n,
  input logic rd_op,
  input logic xfer_n,
  input logic dma_req,
  input logic dma_done,
  input logic ack_lvl,
  input logic accept,
  input logic sel_hi
);
  assert_xfer_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xfer_n) |-> $past(accept));

  assert_xfer_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_n && !ack_lvl) |=> xfer_n);

  assert_req_on_high_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_req) |-> ($past(accept) && $past(sel_hi)));

  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && !dma_done && rd_op) |=> dma_req);

  assert_done_to_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && dma_done) |=> !sel_hi);

  assert_no_take_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> !accept);

  assert_idle_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_op |=> (xfer_n && !dma_req));
endmodule

bind tape_rd_pair_asm tape_rd_pair_asm_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .rd_op    (rd_op),
  .xfer_n   (xfer_n),
  .dma_req  (dma_req),
  .dma_done (dma_done),
  .ack_lvl  (ack_lvl),
  .accept   (accept),
  .sel_hi   (sel == tape_rd_pkg::HALF_HI)
);

// File: tb/tape_rd_pair_asm_tb.sv
`timescale 1ns/1ps
module tape_rd_pair_asm_tb_top;
  localparam int CLK_PERIOD = 250;
  localparam int WDOG_CYCLES = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_op = 1'b0;
  logic        ack_n = 1'b1;
  logic [7:0]  tape_data = '0;
  logic        dma_done = 1'b0;
  logic        xfer_n;
  logic        dma_req;
  logic [15:0] word_out;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tape_rd_pair_asm dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_op     (rd_op),
    .ack_n     (ack_n),
    .tape_data (tape_data),
    .xfer_n    (xfer_n),
    .dma_req   (dma_req),
    .dma_done  (dma_done),
    .word_out  (word_out)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Normal byte: accepted, answered, released
  task automatic send_byte(input logic [7:0] b, input string req);
    tape_data = b;
    ack_n = 1'b0;
    tick(2);
    check(xfer_n == 1'b1, "R2", "strobe too early", 16'(xfer_n), 16'h1);
    tick(1);
    check(xfer_n == 1'b0, req, "strobe after accept", 16'(xfer_n), 16'h0);
    ack_n = 1'b1;
    tick(2);
    check(xfer_n == 1'b0, "R4", "strobe held before release", 16'(xfer_n), 16'h0);
    tick(1);
    check(xfer_n == 1'b1, "R4", "strobe released", 16'(xfer_n), 16'h1);
  endtask

  task automatic pulse_done();
    dma_done = 1'b1;
    tick(1);
    dma_done = 1'b0;
  endtask

  task automatic t_reset();
    check(xfer_n == 1'b1, "R1", "xfer_n at reset", 16'(xfer_n), 16'h1);
    check(dma_req == 1'b0, "R1", "dma_req at reset", 16'(dma_req), 16'h0);
    check(word_out == 16'h0, "R1", "word at reset", word_out, 16'h0);
  endtask

  task automatic t_pair();
    send_byte(8'h41, "R3");
    check(word_out == 16'h0041, "R3", "low byte first", word_out, 16'h0041);
    check(dma_req == 1'b0, "R5", "no req after one byte", 16'(dma_req), 16'h0);
    tape_data = 8'h31;
    ack_n = 1'b0;
    tick(3);
    check(word_out == 16'h3141, "R3", "high byte second", word_out, 16'h3141);
    check(dma_req == 1'b1, "R5", "req with high byte", 16'(dma_req), 16'h1);
    ack_n = 1'b1;
    tick(6);
    check(dma_req == 1'b1, "R5", "req held", 16'(dma_req), 16'h1);
  endtask

  task automatic t_done();
    pulse_done();
    check(dma_req == 1'b0, "R6", "req cleared by done", 16'(dma_req), 16'h0);
    send_byte(8'hA5, "R6");
    check(word_out == 16'h31A5, "R6", "after done into low", word_out, 16'h31A5);
    send_byte(8'h5A, "R3");
    check(word_out == 16'h5AA5, "R3", "second pair high", word_out, 16'h5AA5);
    check(dma_req == 1'b1, "R5", "second req", 16'(dma_req), 16'h1);
  endtask

  task automatic t_early_third();
    tape_data = 8'hC3;
    ack_n = 1'b0;
    tick(6);
    check(xfer_n == 1'b1, "R7", "no strobe while pending", 16'(xfer_n), 16'h1);
    check(word_out == 16'h5AA5, "R7", "word kept while pending", word_out, 16'h5AA5);
    pulse_done();
    check(dma_req == 1'b0, "R7", "req cleared", 16'(dma_req), 16'h0);
    check(xfer_n == 1'b1, "R7", "not yet answered", 16'(xfer_n), 16'h1);
    tick(1);
    check(xfer_n == 1'b0, "R7", "answered after done", 16'(xfer_n), 16'h0);
    check(word_out == 16'h5AC3, "R7", "held byte into low", word_out, 16'h5AC3);
    ack_n = 1'b1;
    tick(3);
    check(xfer_n == 1'b1, "R4", "release after held byte", 16'(xfer_n), 16'h1);
    send_byte(8'h77, "R3");
    check(word_out == 16'h77C3, "R3", "pair after held", word_out, 16'h77C3);
    pulse_done();
  endtask

  task automatic t_long_ack();
    tape_data = 8'h22;
    ack_n = 1'b0;
    tick(12);
    check(word_out == 16'h7722, "R9", "long ack one byte", word_out, 16'h7722);
    check(dma_req == 1'b0, "R9", "long ack no pair", 16'(dma_req), 16'h0);
    check(xfer_n == 1'b0, "R4", "strobe during long ack", 16'(xfer_n), 16'h0);
    ack_n = 1'b1;
    tick(3);
  endtask

  task automatic t_rd_off();
    send_byte(8'h99, "R3");
    check(dma_req == 1'b1, "R5", "req before disable", 16'(dma_req), 16'h1);
    rd_op = 1'b0;
    tick(1);
    check(dma_req == 1'b0, "R8", "disable clears req", 16'(dma_req), 16'h0);
    tape_data = 8'hEE;
    ack_n = 1'b0;
    tick(6);
    check(xfer_n == 1'b1, "R8", "no strobe when off", 16'(xfer_n), 16'h1);
    check(word_out == 16'h9922, "R8", "word kept when off", word_out, 16'h9922);
    ack_n = 1'b1;
    tick(3);
    rd_op = 1'b1;
    tick(1);
    send_byte(8'h44, "R8");
    check(word_out == 16'h9944, "R8", "low after re-enable", word_out, 16'h9944);
  endtask

  initial begin
    tick(2);
    t_reset();
    rst_n = 1'b1;
    rd_op = 1'b1;
    tick(2);
    t_pair();
    t_done();
    t_early_third();
    t_long_ack();
    t_rd_off();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < WDOG_CYCLES; i++) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule